// File: doc/BRIEF.md
# Overcurrent Fault Mode Controller

This block takes the raw threshold-crossed flags from the drain-source comparators of the power switches and from the sense-resistor comparators, and decides what to do about them. Each flag passes through its own deglitch filter and must stay high for a programmable number of clock cycles before it counts as an overcurrent. A 2-bit policy input then picks the response. The block can shut the bridge off until a clear arrives. It can shut the bridge off and release it after a selectable retry time. It can only report the event. It can also ignore overcurrent entirely.

The outputs are a bridge-off command for the gate logic, an active-low fault indication and a sticky status bit for each comparator source. Faults are cleared in one of two ways: a one-cycle clear request, or a low pulse on the enable input whose length falls inside a set window. A longer low period on enable is reported as sleep and does not clear anything. Comparators, threshold selection and register access stay outside the block.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: A flag counts as a qualified overcurrent only after it has been sampled high on DEG_CYC consecutive clock edges. Its status bit is visible one cycle after qualification. A shorter high run leaves no trace on any output.
- R2: With mode_i = 2'b00 (latched), a qualified overcurrent on any channel drives gate_off_o high one cycle after qualification. gate_off_o then stays high after the flag is gone, until an accepted clear.
- R3: With mode_i = 2'b01 (retry), a qualified overcurrent drives gate_off_o high. gate_off_o stays high for exactly T cycles after the last qualified cycle and then drops on its own. T is RETRY_LONG_CYC when retry_sel_i = 0 and RETRY_SHORT_CYC when retry_sel_i = 1.
- R4: With mode_i = 2'b10 (report only), a qualified overcurrent sets its status bit and pulls fault_no low. gate_off_o stays low.
- R5: With mode_i = 2'b11 all channels are ignored. sen_dis_i = 1 ignores only the sense channels in any mode, and the drain-source channels keep working.
- R6: Status bits are sticky in every mode until an accepted clear. Bit i of vds_stat_o belongs to vds_flag_i[i], and bit j of sen_stat_o belongs to sen_flag_i[j]. fault_no is low exactly when any status bit is set.
- R7: clr_i high on a clock edge clears all status bits, the latch and the retry timer. The request is ignored if any qualified overcurrent is active on that edge.
- R8: If enable_i has been low on N consecutive edges and is then sampled high, the same clear as R7 happens on that edge when RST_MIN_CYC <= N <= RST_MAX_CYC. Any other N clears nothing.
- R9: sleep_o rises once enable_i has been low on more than RST_MAX_CYC consecutive edges. It falls one cycle after enable_i is sampled high.
- R10: After reset gate_off_o = 0, fault_no = 1, sleep_o = 0 and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Fault policy: 00 latched, 01 retry, 10 report only, 11 off |
| retry_sel_i | input | 1 | Retry time select: 0 long, 1 short |
| sen_dis_i | input | 1 | Ignore the sense-resistor channels |
| clr_i | input | 1 | Clear request, sampled on each edge |
| enable_i | input | 1 | Enable line; a low pulse in the window clears faults |
| vds_flag_i | input | NUM_VDS | Raw drain-source comparator flags |
| sen_flag_i | input | NUM_SEN | Raw sense-resistor comparator flags |
| gate_off_o | output | 1 | Bridge-off command |
| fault_no | output | 1 | Fault indication, active low |
| vds_stat_o | output | NUM_VDS | Sticky drain-source status |
| sen_stat_o | output | NUM_SEN | Sticky sense status |
| sleep_o | output | 1 | Enable held low past the clear window |

## Verification
Directed runs hold single flags high for one cycle less than the deglitch length and for exactly that length. This separates a filter that is off by one from a correct one. The latched, short-retry, long-retry and report-only policies get the same stimulus, so only the gate_off_o timing and the status bits tell the policies apart. Enable pulses one cycle below, at and above the window edges separate a correct window from one that is off by one, and from one that confuses a clear with sleep. A seeded random phase toggles flags with mixed run lengths while it changes policy, issues clears and pulses enable, and a cycle reference model computed in the bench checks every output.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    OCP_LATCH  = 2'b00,
    OCP_RETRY  = 2'b01,
    OCP_REPORT = 2'b10,
    OCP_OFF    = 2'b11
  } ocp_mode_e;
endpackage

// File: rtl/ocp_deglitch.sv
module ocp_deglitch #(
  parameter int unsigned DEG_CYC = 45
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(DEG_CYC + 1);
  localparam logic [CW-1:0] TOP = CW'(DEG_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!raw_i)      cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign q_o = (cnt_q == TOP);

  assert_q_needs_raw_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o |-> $past(raw_i));
  assert_low_drops_q_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_i |=> !q_o);
endmodule

// File: rtl/ocp_en_pulse.sv
module ocp_en_pulse #(
  parameter int unsigned RST_MIN_CYC = 150,
  parameter int unsigned RST_MAX_CYC = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  output logic clr_o,
  output logic sleep_o
);
  localparam int unsigned LIM = RST_MAX_CYC + 1;
  localparam int unsigned CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] MINV = CW'(RST_MIN_CYC);
  localparam logic [CW-1:0] MAXV = CW'(RST_MAX_CYC);
  localparam logic [CW-1:0] LIMV = CW'(LIM);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            low_q <= '0;
    else if (enable_i)      low_q <= '0;
    else if (low_q != LIMV) low_q <= low_q + 1'b1;
  end

  // clear fires on the first high sample after a low run inside the window
  assign clr_o   = enable_i && (low_q >= MINV) && (low_q <= MAXV);
  assign sleep_o = (low_q == LIMV);

  assert_clr_on_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> (enable_i && !$past(enable_i)));
  assert_sleep_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !$past(enable_i));
endmodule

// File: rtl/ocp_policy.sv
module ocp_policy
  import ocp_pkg::*;
#(
  parameter int unsigned NCH             = 9,
  parameter int unsigned RETRY_LONG_CYC  = 40000,
  parameter int unsigned RETRY_SHORT_CYC = 5000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  ocp_mode_e      mode_i,
  input  logic           retry_sel_i,
  input  logic [NCH-1:0] q_i,
  input  logic           clr_req_i,
  output logic [NCH-1:0] stat_o,
  output logic           gate_off_o,
  output logic           clr_ok_o
);
  localparam int unsigned RMAX = (RETRY_LONG_CYC > RETRY_SHORT_CYC) ? RETRY_LONG_CYC
                                                                    : RETRY_SHORT_CYC;
  localparam int unsigned RW = $clog2(RMAX + 1);
  localparam logic [RW-1:0] RLONG  = RW'(RETRY_LONG_CYC);
  localparam logic [RW-1:0] RSHORT = RW'(RETRY_SHORT_CYC);

  logic [NCH-1:0] stat_q;
  logic           lat_q;
  logic [RW-1:0]  rty_q;
  logic           any_oc;

  assign any_oc   = |q_i;
  assign clr_ok_o = clr_req_i && !any_oc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      lat_q  <= 1'b0;
      rty_q  <= '0;
    end else if (clr_ok_o) begin
      stat_q <= '0;
      lat_q  <= 1'b0;
      rty_q  <= '0;
    end else begin
      stat_q <= stat_q | q_i;
      if (mode_i == OCP_LATCH && any_oc) lat_q <= 1'b1;
      if (mode_i == OCP_RETRY && any_oc) rty_q <= retry_sel_i ? RSHORT : RLONG;
      else if (rty_q != '0)              rty_q <= rty_q - 1'b1;
    end
  end

  assign stat_o     = stat_q;
  assign gate_off_o = lat_q | (rty_q != '0);

  assert_latch_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OCP_LATCH && any_oc) |=> gate_off_o);
  assert_retry_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OCP_RETRY && any_oc) |=> gate_off_o);
  assert_report_no_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OCP_REPORT && !gate_off_o) |=> !gate_off_o);
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ok_o |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
  assert_clear_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_oc |=> ((stat_o & $past(q_i)) == $past(q_i)));
endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
  import ocp_pkg::*;
#(
  parameter int unsigned NUM_VDS         = 6,
  parameter int unsigned NUM_SEN         = 3,
  parameter int unsigned DEG_CYC         = 45,
  parameter int unsigned RETRY_LONG_CYC  = 40000,
  parameter int unsigned RETRY_SHORT_CYC = 5000,
  parameter int unsigned RST_MIN_CYC     = 150,
  parameter int unsigned RST_MAX_CYC     = 400
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               retry_sel_i,
  input  logic               sen_dis_i,
  input  logic               clr_i,
  input  logic               enable_i,
  input  logic [NUM_VDS-1:0] vds_flag_i,
  input  logic [NUM_SEN-1:0] sen_flag_i,
  output logic               gate_off_o,
  output logic               fault_no,
  output logic [NUM_VDS-1:0] vds_stat_o,
  output logic [NUM_SEN-1:0] sen_stat_o,
  output logic               sleep_o
);
  localparam int unsigned NCH = NUM_VDS + NUM_SEN;

  ocp_mode_e      mode;
  logic           vds_en, sen_en;
  logic [NCH-1:0] raw, q, stat;
  logic           en_clr, clr_req, clr_ok;

  assign mode   = ocp_mode_e'(mode_i);
  assign vds_en = (mode != OCP_OFF);
  assign sen_en = vds_en && !sen_dis_i;

  assign raw[NUM_VDS-1:0]   = vds_flag_i & {NUM_VDS{vds_en}};
  assign raw[NCH-1:NUM_VDS] = sen_flag_i & {NUM_SEN{sen_en}};

  for (genvar i = 0; i < NCH; i++) begin : g_deg
    ocp_deglitch #(.DEG_CYC(DEG_CYC)) u_deg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[i]),
      .q_o   (q[i])
    );
  end

  ocp_en_pulse #(
    .RST_MIN_CYC(RST_MIN_CYC),
    .RST_MAX_CYC(RST_MAX_CYC)
  ) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .clr_o   (en_clr),
    .sleep_o (sleep_o)
  );

  assign clr_req = clr_i | en_clr;

  ocp_policy #(
    .NCH            (NCH),
    .RETRY_LONG_CYC (RETRY_LONG_CYC),
    .RETRY_SHORT_CYC(RETRY_SHORT_CYC)
  ) u_pol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .retry_sel_i(retry_sel_i),
    .q_i        (q),
    .clr_req_i  (clr_req),
    .stat_o     (stat),
    .gate_off_o (gate_off_o),
    .clr_ok_o   (clr_ok)
  );

  assign vds_stat_o = stat[NUM_VDS-1:0];
  assign sen_stat_o = stat[NCH-1:NUM_VDS];
  assign fault_no   = ~|stat;

  assert_off_mode_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == OCP_OFF && $past(mode) == OCP_OFF && !(|stat)) |=> !(|stat));
  assert_clear_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ok |=> (fault_no && !gate_off_o));
endmodule

// File: tb/sim_ocp_fault_ctrl.sv
module sim_ocp_fault_ctrl;
  localparam int NV = 6, NS = 3, DEG = 6, RL = 120, RS = 30, PMIN = 8, PMAX = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic rsel = 1'b0, sdis = 1'b0, clr = 1'b0, en = 1'b1;
  logic [NV-1:0] vds = '0;
  logic [NS-1:0] sen = '0;
  logic gate_off, fault_n, sleep;
  logic [NV-1:0] vstat;
  logic [NS-1:0] sstat;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ocp_fault_ctrl #(
    .NUM_VDS(NV), .NUM_SEN(NS), .DEG_CYC(DEG), .RETRY_LONG_CYC(RL),
    .RETRY_SHORT_CYC(RS), .RST_MIN_CYC(PMIN), .RST_MAX_CYC(PMAX)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .retry_sel_i(rsel), .sen_dis_i(sdis),
    .clr_i(clr), .enable_i(en), .vds_flag_i(vds), .sen_flag_i(sen),
    .gate_off_o(gate_off), .fault_no(fault_n), .vds_stat_o(vstat),
    .sen_stat_o(sstat), .sleep_o(sleep)
  );

  // cycle reference model built from the requirements
  int m_rv[NV];
  int m_rs[NS];
  logic [NV+NS-1:0] m_stat;
  logic m_lat;
  int m_rty, m_low;

  always @(posedge clk or negedge rst_n) begin : model
    logic [NV+NS-1:0] q;
    logic any, ok;
    if (!rst_n) begin
      for (int i = 0; i < NV; i++) m_rv[i] <= 0;
      for (int i = 0; i < NS; i++) m_rs[i] <= 0;
      m_stat <= '0; m_lat <= 1'b0; m_rty <= 0; m_low <= 0;
    end else begin
      for (int i = 0; i < NV; i++) q[i] = (m_rv[i] >= DEG);
      for (int i = 0; i < NS; i++) q[NV+i] = (m_rs[i] >= DEG);
      any = |q;
      ok = (clr || (en && m_low >= PMIN && m_low <= PMAX)) && !any;
      for (int i = 0; i < NV; i++)
        m_rv[i] <= (vds[i] && mode != 2'b11) ? ((m_rv[i] < DEG) ? m_rv[i] + 1 : DEG) : 0;
      for (int i = 0; i < NS; i++)
        m_rs[i] <= (sen[i] && mode != 2'b11 && !sdis) ? ((m_rs[i] < DEG) ? m_rs[i] + 1 : DEG) : 0;
      m_stat <= ok ? '0 : (m_stat | q);
      m_lat  <= ok ? 1'b0 : ((mode == 2'b00 && any) ? 1'b1 : m_lat);
      m_rty  <= ok ? 0 : ((mode == 2'b01 && any) ? (rsel ? RS : RL) : ((m_rty > 0) ? m_rty - 1 : 0));
      m_low  <= en ? 0 : m_low + 1;
    end
  end

  function automatic logic [NV+NS+2:0] model_out();
    return {m_low > PMAX, ~|m_stat, (m_lat || m_rty > 0), m_stat};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  task automatic make_fault(int ch);
    vds[ch] = 1'b1; step(DEG + 1); vds[ch] = 1'b0; step(2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int low_left;
    void'($urandom(32'd20240611));
    step(3);
    chk("R10 reset gate_off", gate_off, 0);
    chk("R10 reset fault_no", fault_n, 1);
    chk("R10 reset status", {sstat, vstat}, 0);
    chk("R10 reset sleep", sleep, 0);
    rst_n = 1'b1;
    step(2);

    // R1 glitch one cycle short
    vds[2] = 1'b1; step(DEG - 1); vds[2] = 1'b0; step(3);
    chk("R1 short glitch status", vstat, 0);
    chk("R1 short glitch gate", gate_off, 0);

    // R1/R2 exact qualification, latch
    vds[2] = 1'b1; step(DEG);
    chk("R1 status not yet", vstat, 0);
    step(1);
    chk("R1 status set", vstat, 6'h04);
    chk("R2 latched gate_off", gate_off, 1);
    chk("R6 fault_no low", fault_n, 0);
    vds[2] = 1'b0; step(10);
    chk("R2 latch holds", gate_off, 1);
    chk("R6 sticky", vstat, 6'h04);
    pulse_clr();
    chk("R7 clear status", vstat, 0);
    chk("R7 clear gate", gate_off, 0);
    chk("R7 clear fault_no", fault_n, 1);

    // R7 clear ignored while active
    sen[1] = 1'b1; step(DEG + 1);
    chk("R6 sense status map", sstat, 3'b010);
    pulse_clr();
    chk("R7 clear ignored while active", sstat, 3'b010);
    chk("R7 gate kept while active", gate_off, 1);
    sen[1] = 1'b0; step(2); pulse_clr();
    chk("R7 clear after release", {gate_off, sstat}, 0);

    // R3 short and long retry
    for (int k = 0; k < 2; k++) begin
      int t;
      mode = 2'b01; rsel = (k == 0); t = (k == 0) ? RS : RL;
      vds[0] = 1'b1; step(DEG + 1);
      chk("R3 retry gate_off", gate_off, 1);
      vds[0] = 1'b0; step(t);
      chk("R3 still off at end of retry", gate_off, 1);
      step(1);
      chk("R3 released after retry", gate_off, 0);
      chk("R6 status kept after retry", vstat, 6'h01);
      chk("R6 fault_no kept after retry", fault_n, 0);
      pulse_clr();
    end

    // R4 report only
    mode = 2'b10;
    sen[0] = 1'b1; step(DEG + 1);
    chk("R4 report status", sstat, 3'b001);
    chk("R4 report fault_no", fault_n, 0);
    step(5);
    chk("R4 report no gate_off", gate_off, 0);
    sen[0] = 1'b0; step(2); pulse_clr();

    // R5 off mode
    mode = 2'b11; vds = '1; sen = '1; step(DEG + 5);
    chk("R5 off mode status", {sstat, vstat}, 0);
    chk("R5 off mode gate", gate_off, 0);
    chk("R5 off mode fault_no", fault_n, 1);
    vds = '0; sen = '0; step(2);

    // R5 sense disable alone
    mode = 2'b00; sdis = 1'b1; sen = '1; step(DEG + 3);
    chk("R5 sense disabled", {gate_off, sstat}, 0);
    vds[5] = 1'b1; step(DEG + 1);
    chk("R5 vds still active", vstat, 6'h20);
    chk("R5 vds still shuts off", gate_off, 1);
    vds = '0; sen = '0; sdis = 1'b0; step(2); pulse_clr();

    // R8/R9 enable pulse window
    mode = 2'b10; make_fault(1);
    en = 1'b0; step(PMIN - 1); en = 1'b1; step(1);
    chk("R8 pulse too short", vstat, 6'h02);
    en = 1'b0; step(PMIN); en = 1'b1; step(1);
    chk("R8 pulse at minimum clears", vstat, 0);
    make_fault(3);
    en = 1'b0; step(PMAX); en = 1'b1; step(1);
    chk("R8 pulse at maximum clears", vstat, 0);
    make_fault(4);
    en = 1'b0; step(PMAX);
    chk("R9 no sleep at maximum", sleep, 0);
    step(1);
    chk("R9 sleep past maximum", sleep, 1);
    en = 1'b1; step(1);
    chk("R8 long low does not clear", vstat, 6'h10);
    chk("R9 sleep released", sleep, 0);
    pulse_clr();

    // random phase against the reference model
    low_left = 0;
    for (int c = 0; c < 4000; c++) begin
      chk("R1/R2/R3/R4/R5/R6/R7/R8/R9 random", {sleep, fault_n, gate_off, sstat, vstat}, model_out());
      for (int i = 0; i < NV; i++) if ($urandom % 14 == 0) vds[i] = ~vds[i];
      for (int i = 0; i < NS; i++) if ($urandom % 14 == 0) sen[i] = ~sen[i];
      if ($urandom % 400 == 0) begin
        mode = 2'($urandom % 4); rsel = 1'($urandom % 2); sdis = ($urandom % 6 == 0);
      end
      clr = ($urandom % 150 == 0);
      if (low_left > 0) begin en = 1'b0; low_left--; end
      else begin
        en = 1'b1;
        if ($urandom % 250 == 0) low_left = 1 + int'($urandom % 28);
      end
      step(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule